// File: doc/BRIEF.md
# Multi-format serial audio receiver

This block turns a serial audio stream into parallel left and right samples for a playback converter. The bit clock, frame clock and data line come from an external master. They are brought into the system clock domain by synchronizers. Every rising bit-clock edge becomes a one-cycle bit event, and the frame clock and the data bit are sampled with it. A two-bit format code picks one of four framings, and a two-bit length code sets how many bits make up one word.

After a word is captured it is left-aligned into a 24-bit sample. A left word is held until the matching right word arrives. Each output channel then takes either the received left or the received right word, by its own select. In the frame-sync format a frame carries two stereo slots. The receiver keeps only one of them, which is slot 0 unless slot filtering is enabled and slot 1 is chosen. Both outputs change together, on the cycle of a one-cycle valid strobe that is raised once per accepted frame.

Each level of the bit clock must last at least three system clock cycles.

Top module: `serial_audio_rx`

## Requirements
- R1: While `rst` is high, and on the first cycle after it, both sample outputs are zero and `sample_valid` is low.
- R2: With `fmt_sel`=01 (left justified), the frame clock high marks the left channel. The MSB is the data bit sampled on the first rising bit clock at which the frame clock has changed level.
- R3: With `fmt_sel`=10 (I2S), the frame clock low marks the left channel. The MSB is sampled on the second rising bit clock after the frame clock changes level.
- R4: With `fmt_sel`=00 (right justified), the frame clock high marks the left channel. A word is the last N bits sampled before the frame clock changes level, with the LSB last. Earlier bits in that half are discarded.
- R5: With `fmt_sel`=11 (frame sync), a frame starts at the first rising bit clock on which the frame clock reads high after reading low. Four N-bit words then follow back to back, MSB first and starting one bit clock later, in the order slot-0 left, slot-0 right, slot-1 left, slot-1 right.
- R6: N follows `wlen_sel`: 00 gives 16 bits, 01 gives 20, 10 gives 24 and 11 gives 8. Bit clocks beyond the N bits of a word have no effect on the outputs.
- R7: A captured N-bit word appears on the outputs in bits 23 down to 24-N, and the low 24-N bits are zero.
- R8: `dac_left` carries the received left word when `src_l_sel`=0 and the received right word when it is 1. `dac_right` follows `src_r_sel` in the same way.
- R9: In frame-sync mode, only slot `tdm_slot` is kept when `tdm_en`=1, and only slot 0 is kept when `tdm_en`=0. Words of the other slot leave the outputs unchanged. In the other three formats `tdm_en` and `tdm_slot` have no effect.
- R10: `sample_valid` pulses for exactly one cycle per accepted frame, after its right word is complete. The outputs change only on that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bclk_i | input | 1 | External bit clock |
| lrclk_i | input | 1 | External frame / channel clock |
| sdata_i | input | 1 | Serial data, MSB first |
| fmt_sel | input | 2 | Framing: 00 right justified, 01 left justified, 10 I2S, 11 frame sync |
| wlen_sel | input | 2 | Word length: 00=16, 01=20, 10=24, 11=8 bits |
| src_l_sel | input | 1 | Left output source: 0 received left, 1 received right |
| src_r_sel | input | 1 | Right output source: 0 received left, 1 received right |
| tdm_en | input | 1 | Enable slot filtering in frame-sync mode |
| tdm_slot | input | 1 | Slot kept when filtering is enabled |
| dac_left | output | 24 | Left-aligned left output sample |
| dac_right | output | 24 | Left-aligned right output sample |
| sample_valid | output | 1 | One-cycle strobe when both outputs update |

## Verification
On every cycle the assertions check the reset values and the single-cycle valid pulse. They also check that the outputs never move without the strobe, that a strobe always follows a captured right word, that each captured word has zero low bits, that the outputs are equal whenever both selects matched, and that the word behind a strobe came from the allowed slot. Where the MSB sits in each framing, how long the words are, that padding bits are dropped, and which slot's data reaches the outputs can only be shown by the bench. It sends known serial frames and compares every strobe with the sample pair it expects.

// File: rtl/audio_rx_pkg.sv
package audio_rx_pkg;

    localparam int SAMPLE_W = 24;
    localparam int CNT_W    = $clog2(SAMPLE_W + 1);

    typedef enum logic [1:0] {
        FMT_RJ  = 2'b00,
        FMT_LJ  = 2'b01,
        FMT_I2S = 2'b10,
        FMT_DSP = 2'b11
    } fmt_e;

    // One captured word travelling from the deserializer to the router
    typedef struct packed {
        logic [SAMPLE_W-1:0] data;     // left-aligned, zero-filled
        logic                is_right; // 0 left channel, 1 right channel
        logic                slot;     // slot index (frame-sync mode only)
        logic                slotted;  // word is subject to slot filtering
    } rx_word_t;

    function automatic logic [CNT_W-1:0] wlen_bits(input logic [1:0] code);
        case (code)
            2'b00:   return CNT_W'(16);
            2'b01:   return CNT_W'(20);
            2'b10:   return CNT_W'(24);
            default: return CNT_W'(8);
        endcase
    endfunction

    function automatic logic [SAMPLE_W-1:0] left_align(input logic [SAMPLE_W-1:0] raw,
                                                       input logic [CNT_W-1:0]    n);
        logic [CNT_W-1:0] amt;
        amt = CNT_W'(SAMPLE_W) - n;
        return raw << amt;
    endfunction

endpackage

// File: rtl/rx_edge_sync.sv
module rx_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic bclk_i,
    input  logic lrclk_i,
    input  logic sdata_i,
    output logic bit_stb,
    output logic lr_lvl,
    output logic sd_bit
);
    localparam int LANES = 3;

    logic [STAGES-1:0][LANES-1:0] chain;
    logic                         bclk_d;
    logic [LANES-1:0]             synced;

    assign synced = chain[STAGES-1];

    always_ff @(posedge clk) begin
        if (rst) begin
            chain <= '0;
        end else begin
            chain[0] <= {bclk_i, lrclk_i, sdata_i};
            for (int s = 1; s < STAGES; s++) begin
                chain[s] <= chain[s-1];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            bclk_d  <= 1'b0;
            bit_stb <= 1'b0;
            lr_lvl  <= 1'b0;
            sd_bit  <= 1'b0;
        end else begin
            bclk_d  <= synced[2];
            bit_stb <= synced[2] & ~bclk_d;
            lr_lvl  <= synced[1];
            sd_bit  <= synced[0];
        end
    end
endmodule

// File: rtl/rx_frame_deser.sv
module rx_frame_deser
    import audio_rx_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     bit_stb,
    input  logic     lr_lvl,
    input  logic     sd_bit,
    input  fmt_e     fmt,
    input  logic [1:0] wlen_code,
    output logic     word_stb,
    output rx_word_t word
);
    logic                prev_lr;
    logic                prev_ok;
    logic                rj_armed;
    logic                active;
    logic                cur_right;
    logic [1:0]          widx;
    logic [CNT_W-1:0]    cnt;
    logic [SAMPLE_W-1:0] sh;

    logic [CNT_W-1:0]    nbits;
    logic [CNT_W-1:0]    cnt_nx;
    logic [SAMPLE_W-1:0] sh_in;
    logic                lr_edge;
    logic                lr_rise;

    always_comb begin
        nbits   = wlen_bits(wlen_code);
        cnt_nx  = cnt + CNT_W'(1);
        sh_in   = {sh[SAMPLE_W-2:0], sd_bit};
        lr_edge = prev_ok && (lr_lvl != prev_lr);
        lr_rise = prev_ok && lr_lvl && !prev_lr;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_lr   <= 1'b0;
            prev_ok   <= 1'b0;
            rj_armed  <= 1'b0;
            active    <= 1'b0;
            cur_right <= 1'b0;
            widx      <= '0;
            cnt       <= '0;
            sh        <= '0;
            word_stb  <= 1'b0;
            word      <= '0;
        end else begin
            word_stb <= 1'b0;
            if (bit_stb) begin
                prev_lr <= lr_lvl;
                prev_ok <= 1'b1;
                unique case (fmt)
                    FMT_RJ: begin
                        // keep shifting; the channel change closes the word
                        sh <= sh_in;
                        if (lr_edge) begin
                            rj_armed <= 1'b1;
                            if (rj_armed) begin
                                word_stb <= 1'b1;
                                word <= '{data: left_align(sh, nbits),
                                          is_right: !prev_lr, slot: 1'b0, slotted: 1'b0};
                            end
                        end
                    end
                    FMT_LJ, FMT_I2S: begin
                        if (lr_edge) begin
                            active    <= 1'b1;
                            cur_right <= (fmt == FMT_LJ) ? !lr_lvl : lr_lvl;
                            if (fmt == FMT_LJ) begin
                                sh  <= SAMPLE_W'(sd_bit);
                                cnt <= CNT_W'(1);
                            end else begin
                                sh  <= '0;
                                cnt <= '0;
                            end
                        end else if (active) begin
                            sh  <= sh_in;
                            cnt <= cnt_nx;
                            if (cnt_nx == nbits) begin
                                active   <= 1'b0;
                                word_stb <= 1'b1;
                                word <= '{data: left_align(sh_in, nbits),
                                          is_right: cur_right, slot: 1'b0, slotted: 1'b0};
                            end
                        end
                    end
                    FMT_DSP: begin
                        if (lr_rise) begin
                            active <= 1'b1;
                            cnt    <= '0;
                            widx   <= '0;
                            sh     <= '0;
                        end else if (active) begin
                            if (cnt_nx == nbits) begin
                                word_stb <= 1'b1;
                                word <= '{data: left_align(sh_in, nbits),
                                          is_right: widx[0], slot: widx[1], slotted: 1'b1};
                                cnt  <= '0;
                                sh   <= '0;
                                widx <= widx + 2'd1;
                                if (widx == 2'd3) begin
                                    active <= 1'b0;
                                end
                            end else begin
                                sh  <= sh_in;
                                cnt <= cnt_nx;
                            end
                        end
                    end
                endcase
            end
        end
    end
endmodule

// File: rtl/rx_chan_router.sv
module rx_chan_router
    import audio_rx_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                word_stb,
    input  rx_word_t            word,
    input  logic                src_l_sel,
    input  logic                src_r_sel,
    input  logic                tdm_en,
    input  logic                tdm_slot,
    output logic [SAMPLE_W-1:0] dac_left,
    output logic [SAMPLE_W-1:0] dac_right,
    output logic                sample_valid
);
    localparam int NCH = 2;

    logic                want_slot;
    logic                accept;
    logic                take_right;
    logic [NCH-1:0]      sel_v;
    logic [SAMPLE_W-1:0] held_left;

    always_comb begin
        want_slot  = tdm_en ? tdm_slot : 1'b0;
        accept     = word_stb && (!word.slotted || (word.slot == want_slot));
        take_right = accept && word.is_right;
        sel_v      = {src_r_sel, src_l_sel};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            held_left    <= '0;
            sample_valid <= 1'b0;
        end else begin
            sample_valid <= take_right;
            if (accept && !word.is_right) begin
                held_left <= word.data;
            end
        end
    end

    for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
        logic [SAMPLE_W-1:0] q;
        always_ff @(posedge clk) begin
            if (rst) begin
                q <= '0;
            end else if (take_right) begin
                q <= sel_v[ch] ? word.data : held_left;
            end
        end
    end

    assign dac_left  = g_ch[0].q;
    assign dac_right = g_ch[1].q;
endmodule

// File: rtl/serial_audio_rx.sv
module serial_audio_rx
    import audio_rx_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                bclk_i,
    input  logic                lrclk_i,
    input  logic                sdata_i,
    input  logic [1:0]          fmt_sel,
    input  logic [1:0]          wlen_sel,
    input  logic                src_l_sel,
    input  logic                src_r_sel,
    input  logic                tdm_en,
    input  logic                tdm_slot,
    output logic [SAMPLE_W-1:0] dac_left,
    output logic [SAMPLE_W-1:0] dac_right,
    output logic                sample_valid
);
    logic     bit_stb;
    logic     lr_lvl;
    logic     sd_bit;
    logic     w_stb;
    rx_word_t w_word;

    rx_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst     (rst),
        .bclk_i  (bclk_i),
        .lrclk_i (lrclk_i),
        .sdata_i (sdata_i),
        .bit_stb (bit_stb),
        .lr_lvl  (lr_lvl),
        .sd_bit  (sd_bit)
    );

    rx_frame_deser u_deser (
        .clk       (clk),
        .rst       (rst),
        .bit_stb   (bit_stb),
        .lr_lvl    (lr_lvl),
        .sd_bit    (sd_bit),
        .fmt       (fmt_e'(fmt_sel)),
        .wlen_code (wlen_sel),
        .word_stb  (w_stb),
        .word      (w_word)
    );

    rx_chan_router u_route (
        .clk          (clk),
        .rst          (rst),
        .word_stb     (w_stb),
        .word         (w_word),
        .src_l_sel    (src_l_sel),
        .src_r_sel    (src_r_sel),
        .tdm_en       (tdm_en),
        .tdm_slot     (tdm_slot),
        .dac_left     (dac_left),
        .dac_right    (dac_right),
        .sample_valid (sample_valid)
    );
endmodule

// File: rtl/audio_rx_chk.sv
module audio_rx_chk
    import audio_rx_pkg::*;
(
    input logic                clk,
    input logic                rst,
    input logic                sample_valid,
    input logic [SAMPLE_W-1:0] dac_left,
    input logic [SAMPLE_W-1:0] dac_right,
    input logic                src_l_sel,
    input logic                src_r_sel,
    input logic                tdm_en,
    input logic                tdm_slot,
    input logic [1:0]          wlen_sel,
    input logic                w_stb,
    input rx_word_t            w_word
);
    function automatic logic [SAMPLE_W-1:0] pad_mask(input logic [1:0] code);
        return {SAMPLE_W{1'b1}} >> wlen_bits(code);
    endfunction

    AST_RESET_CLEAR: assert property (@(posedge clk)
        rst |=> (!sample_valid && dac_left == '0 && dac_right == '0)); // R1

    AST_VALID_PULSE: assert property (@(posedge clk) disable iff (rst)
        sample_valid |=> !sample_valid); // R10

    AST_LEFT_HOLD: assert property (@(posedge clk) disable iff (rst)
        !$stable(dac_left) |-> sample_valid); // R10

    AST_RIGHT_HOLD: assert property (@(posedge clk) disable iff (rst)
        !$stable(dac_right) |-> sample_valid); // R10

    AST_VALID_AFTER_RIGHT: assert property (@(posedge clk) disable iff (rst)
        sample_valid |-> $past(w_stb && w_word.is_right)); // R10

    AST_LOW_BITS_ZERO: assert property (@(posedge clk) disable iff (rst)
        w_stb |-> ((w_word.data & pad_mask($past(wlen_sel))) == '0)); // R7

    AST_SAME_SOURCE: assert property (@(posedge clk) disable iff (rst)
        (sample_valid && $past(src_l_sel == src_r_sel)) |-> (dac_left == dac_right)); // R8

    AST_TDM_SLOT: assert property (@(posedge clk) disable iff (rst)
        (sample_valid && $past(tdm_en && w_word.slotted)) |-> $past(w_word.slot == tdm_slot)); // R9

    AST_DEFAULT_SLOT: assert property (@(posedge clk) disable iff (rst)
        (sample_valid && $past(!tdm_en && w_word.slotted)) |-> $past(!w_word.slot)); // R9
endmodule

bind serial_audio_rx audio_rx_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .sample_valid (sample_valid),
    .dac_left     (dac_left),
    .dac_right    (dac_right),
    .src_l_sel    (src_l_sel),
    .src_r_sel    (src_r_sel),
    .tdm_en       (tdm_en),
    .tdm_slot     (tdm_slot),
    .wlen_sel     (wlen_sel),
    .w_stb        (w_stb),
    .w_word       (w_word)
);

// File: tb/tb_serial_audio_rx.sv
module tb_serial_audio_rx;
    localparam int CLK_PERIOD = 10;
    localparam int HB         = 4;       // system clocks per bit-clock level
    localparam int WD_CYCLES  = 150000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bclk = 1'b0, lrclk = 1'b0, sdata = 1'b0;
    logic [1:0]  fmt_sel = 2'b01, wlen_sel = 2'b10;
    logic        src_l_sel = 1'b0, src_r_sel = 1'b1, tdm_en = 1'b0, tdm_slot = 1'b0;
    logic [23:0] dac_left, dac_right;
    logic        sample_valid;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    typedef struct {
        logic [23:0] l;
        logic [23:0] r;
        string       tag;
    } exp_t;
    exp_t sb[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    serial_audio_rx dut (
        .clk(clk), .rst(rst), .bclk_i(bclk), .lrclk_i(lrclk), .sdata_i(sdata),
        .fmt_sel(fmt_sel), .wlen_sel(wlen_sel), .src_l_sel(src_l_sel), .src_r_sel(src_r_sel),
        .tdm_en(tdm_en), .tdm_slot(tdm_slot),
        .dac_left(dac_left), .dac_right(dac_right), .sample_valid(sample_valid)
    );

    task automatic chk(input bit ok, input string req, input logic [23:0] act, input logic [23:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic int nbits(input logic [1:0] code);
        case (code)
            2'b00:   return 16;
            2'b01:   return 20;
            2'b10:   return 24;
            default: return 8;
        endcase
    endfunction

    function automatic logic [23:0] al(input logic [23:0] v, input int n);
        logic [23:0] m;
        m = (24'h1 << n) - 24'h1;
        return (v & m) << (24 - n);
    endfunction

    task automatic push_exp(input logic [23:0] l, input logic [23:0] r, input string tag);
        exp_t e;
        int n;
        n = nbits(wlen_sel);
        e.l = src_l_sel ? al(r, n) : al(l, n);
        e.r = src_r_sel ? al(r, n) : al(l, n);
        e.tag = tag;
        sb.push_back(e);
    endtask

    task automatic bit_out(input logic lr, input logic d);
        @(negedge clk);
        lrclk = lr;
        sdata = d;
        repeat (HB) @(negedge clk);
        bclk = 1'b1;
        repeat (HB) @(negedge clk);
        bclk = 1'b0;
    endtask

    task automatic start(input logic [1:0] f, input logic [1:0] w, input logic sl, input logic sr,
                         input logic te, input logic ts);
        @(negedge clk);
        rst = 1'b1;
        fmt_sel = f; wlen_sel = w; src_l_sel = sl; src_r_sel = sr; tdm_en = te; tdm_slot = ts;
        bclk = 1'b0; sdata = 1'b0;
        lrclk = (f == 2'b10) ? 1'b1 : 1'b0;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        repeat (4) @(negedge clk);
        bit_out(lrclk, 1'b0);
        bit_out(lrclk, 1'b0);
    endtask

    // one stereo frame in a channel-clock format, 32 bit clocks per channel, padding driven high
    task automatic frame_std(input logic [23:0] lw, input logic [23:0] rw, input string tag);
        int n;
        logic left_lvl;
        n = nbits(wlen_sel);
        left_lvl = (fmt_sel == 2'b10) ? 1'b0 : 1'b1;
        push_exp(lw, rw, tag);
        for (int ch = 0; ch < 2; ch++) begin
            logic [23:0] w;
            logic lv;
            w  = (ch == 0) ? lw : rw;
            lv = (ch == 0) ? left_lvl : ~left_lvl;
            for (int i = 0; i < 32; i++) begin
                logic d;
                d = 1'b1;
                case (fmt_sel)
                    2'b01: if (i < n) d = w[n-1-i];
                    2'b10: if (i >= 1 && i <= n) d = w[n-i];
                    default: if (i >= 32 - n) d = w[31-i];
                endcase
                bit_out(lv, d);
            end
        end
    endtask

    task automatic tail_std();
        logic left_lvl;
        left_lvl = (fmt_sel == 2'b10) ? 1'b0 : 1'b1;
        bit_out(left_lvl, 1'b0);
        bit_out(left_lvl, 1'b0);
    endtask

    task automatic frame_dsp(input logic [23:0] l0, input logic [23:0] r0,
                             input logic [23:0] l1, input logic [23:0] r1, input string tag);
        int n;
        logic [23:0] ws [4];
        logic s;
        n = nbits(wlen_sel);
        ws[0] = l0; ws[1] = r0; ws[2] = l1; ws[3] = r1;
        s = tdm_en ? tdm_slot : 1'b0;
        if (s) push_exp(l1, r1, tag);
        else   push_exp(l0, r0, tag);
        bit_out(1'b1, 1'b1);
        for (int k = 0; k < 4; k++) begin
            for (int i = 0; i < n; i++) begin
                bit_out(1'b0, ws[k][n-1-i]);
            end
        end
        for (int p = 0; p < 3; p++) bit_out(1'b0, 1'b1);
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (!rst && !done && sample_valid) begin
            if (sb.size() == 0) begin
                chk(1'b0, "R10 unexpected valid", dac_left, 24'h0);
            end else begin
                exp_t e;
                e = sb.pop_front();
                chk(dac_left === e.l,  {e.tag, " left"},  dac_left,  e.l);
                chk(dac_right === e.r, {e.tag, " right"}, dac_right, e.r);
            end
        end
    end

    initial begin
        repeat (WD_CYCLES) @(posedge clk);
        chk(1'b0, "watchdog expired", 24'h0, 24'h0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(dac_left == 24'h0 && dac_right == 24'h0, "R1 outputs in reset", dac_left, 24'h0);
        chk(sample_valid == 1'b0, "R1 valid in reset", {23'h0, sample_valid}, 24'h0);
        rst = 1'b0;
        @(negedge clk);
        chk(dac_left == 24'h0 && dac_right == 24'h0 && !sample_valid, "R1 after release", dac_right, 24'h0);

        // R2 R6 R7: left justified, 24-bit
        start(2'b01, 2'b10, 1'b0, 1'b1, 1'b0, 1'b0);
        frame_std(24'hA5C3F1, 24'h1234EF, "R2 R6 LJ24");
        frame_std(24'h800001, 24'h7FFFFE, "R2 R7 LJ24");
        tail_std();

        // R3: I2S, 16-bit, padding high must be dropped
        start(2'b10, 2'b00, 1'b0, 1'b1, 1'b0, 1'b0);
        frame_std(24'h00BEEF, 24'h001357, "R3 I2S16");
        frame_std(24'h008001, 24'h007FFE, "R3 R7 I2S16");
        tail_std();

        // R4: right justified, 20-bit, leading padding high
        start(2'b00, 2'b01, 1'b0, 1'b1, 1'b0, 1'b0);
        frame_std(24'h0ABCDE, 24'h013579, "R4 RJ20");
        frame_std(24'h0FFFFF, 24'h000001, "R4 R6 RJ20");
        tail_std();

        // R6 R8: 8-bit left justified with swapped routing
        start(2'b01, 2'b11, 1'b1, 1'b0, 1'b0, 1'b0);
        frame_std(24'h00005A, 24'h0000C3, "R6 R8 swap LJ8");
        tail_std();

        // R8: I2S 24-bit with both outputs taking the right word
        start(2'b10, 2'b10, 1'b1, 1'b1, 1'b0, 1'b0);
        frame_std(24'h0F0F0F, 24'hF0F0F0, "R8 dup right");
        tail_std();

        // R8: both outputs taking the left word
        start(2'b01, 2'b00, 1'b0, 1'b0, 1'b0, 1'b0);
        frame_std(24'h00C0DE, 24'h00FACE, "R8 dup left");
        tail_std();

        // R5 R9: frame sync, 16-bit, filtering off keeps slot 0
        start(2'b11, 2'b00, 1'b0, 1'b1, 1'b0, 1'b0);
        frame_dsp(24'h001111, 24'h002222, 24'h003333, 24'h004444, "R5 R9 DSP16 slot0");
        frame_dsp(24'h00A1A1, 24'h00B2B2, 24'h00C3C3, 24'h00D4D4, "R5 DSP16 slot0");

        // R9: frame sync, 24-bit, slot 1 selected
        start(2'b11, 2'b10, 1'b0, 1'b1, 1'b1, 1'b1);
        frame_dsp(24'h111111, 24'h222222, 24'hABCDEF, 24'h987654, "R9 DSP24 slot1");
        frame_dsp(24'h0F0F0F, 24'hF0F0F0, 24'h135790, 24'h246801, "R9 DSP24 slot1");

        // R9: frame sync, 20-bit, slot 0 selected with filtering on
        start(2'b11, 2'b01, 1'b0, 1'b1, 1'b1, 1'b0);
        frame_dsp(24'h0ABCDE, 24'h012345, 24'h0FFFFF, 24'h0EEEEE, "R9 DSP20 slot0");

        // R9: slot controls ignored in a channel-clock format
        start(2'b01, 2'b00, 1'b0, 1'b1, 1'b1, 1'b1);
        frame_std(24'h004321, 24'h008765, "R9 LJ16 tdm ignored");
        tail_std();

        repeat (40) @(negedge clk);
        // R10: one strobe per frame, none missing
        chk(sb.size() == 0, "R10 missing valid strobes", 24'(sb.size()), 24'h0);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule